// File: doc/BRIEF.md
# Interrupt Polarity, Mask and Latch Front-end

This block conditions up to 64 peripheral interrupt lines before they reach a parent interrupt controller that only accepts active-high level requests. Each raw line is brought into the clock domain by a two-flop synchronizer. A per-line inversion bit can then flip it, so active-low levels and falling edges become active-high. Lines built for edge mode keep each rising edge of the corrected signal in a sticky latch. Lines built for level mode pass the corrected level straight on. A per-line mask bit gates the final output.

Software uses a 16-bit write bus with a combinational read port. There are three register banks: mask, inversion and end-of-interrupt. Each 16-bit register covers sixteen lines, and consecutive registers in a bank sit four bytes apart. An end-of-interrupt write releases the latches of the lines whose bits it sets. A build option removes that handshake: the latches then hold a request for one cycle per edge only, and writes to the end-of-interrupt bank have no effect.

Top module: `irq_front`

## Requirements
- R1: After reset every implemented mask bit is 1 and every inversion bit is 0, all edge latches are clear, and every output is 0.
- R2: Line n maps to bit n%16 of register n/16 in a bank. Register g of the mask bank is at byte address 0x00+4g, of the inversion bank at 0x10+4g, and of the end-of-interrupt bank at 0x20+4g. Bits with no implemented line, and unmapped addresses, read as 0.
- R3: Mask and inversion registers read back the value last written to their implemented bits.
- R4: A line whose mask bit is 1 drives its output to 0.
- R5: When a line's inversion bit is 1, the corrected signal is the complement of the synchronized input. When the bit is 0, the synchronized input passes unchanged.
- R6: Raw inputs pass through two flops. A change on a level-mode line appears at the output after the second rising clock edge, and not after the first.
- R7: On an unmasked level-mode line, the output equals the corrected signal.
- R8: On an edge-mode line, a 0-to-1 transition of the corrected signal sets the latch. The latch stays set after the input returns to 0 and remains set until an end-of-interrupt write releases it.
- R9: Writing 1 to a line's bit in the end-of-interrupt bank clears that line's latch at the write edge. Writing 0 leaves the latch unchanged. The end-of-interrupt bank always reads 0.
- R10: If a new corrected rising edge and an end-of-interrupt write for the same line fall in the same cycle, the latch stays set.
- R11: With the no-handshake option, end-of-interrupt writes have no effect, and each edge sets the latch for exactly one cycle.
- R12: The mask only gates the output. An edge latched while its line is masked appears as soon as the line is unmasked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_LINES | Raw peripheral interrupt lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address for writes and reads |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| irq_out | output | NUM_LINES | Active-high level requests to the parent controller |

## Verification
The bench builds two copies with 20 lines, so the second register of each bank holds only four live bits and the unused bits can be shown to read as zero. Both copies use the same edge/level split: lines 4-7 and 12-19 are edge mode, the rest level mode. One copy keeps the end-of-interrupt handshake and the other is built without it. Both copies share the same stimulus, so one run covers end-of-interrupt writes that release a latch and the same writes having no effect.

// File: rtl/irq_front.sv
module irq_front #(
  parameter int NUM_LINES = 64,
  parameter logic [63:0] EDGE_SEL = 64'hFFFF_FFFF_0000_0000,
  parameter int NO_EOI = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [15:0]          bus_wdata,
  output logic [15:0]          bus_rdata,
  output logic [NUM_LINES-1:0] irq_out
);
  localparam logic [NUM_LINES-1:0] EDGE_LINES = EDGE_SEL[NUM_LINES-1:0];
  localparam logic [7:0] MASK_OFF = 8'h00;
  localparam logic [7:0] POL_OFF  = 8'h10;
  localparam logic [7:0] EOI_OFF  = 8'h20;

  function automatic logic [7:0] reg_addr(input logic [7:0] base, input int line);
    return base + 8'(4 * (line / 16));
  endfunction

  logic [NUM_LINES-1:0] sync1, sync2, prev_q, latch_q, mask_q, pol_q;
  logic [NUM_LINES-1:0] corr, rise, eoi_clr;

  assign corr = sync2 ^ pol_q;
  assign rise = corr & ~prev_q;

  always_comb begin
    eoi_clr = '0;
    for (int n = 0; n < NUM_LINES; n++)
      eoi_clr[n] = (NO_EOI == 0) && bus_wr && (bus_addr == reg_addr(EOI_OFF, n))
                   && bus_wdata[4'(n % 16)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      sync2   <= '0;
      prev_q  <= '0;
      latch_q <= '0;
      mask_q  <= '1;
      pol_q   <= '0;
    end else begin
      sync1   <= irq_in;
      sync2   <= sync1;
      prev_q  <= corr;
      latch_q <= (NO_EOI != 0) ? rise : (rise | (latch_q & ~eoi_clr));
      for (int n = 0; n < NUM_LINES; n++) begin
        if (bus_wr && bus_addr == reg_addr(MASK_OFF, n)) mask_q[n] <= bus_wdata[4'(n % 16)];
        if (bus_wr && bus_addr == reg_addr(POL_OFF, n))  pol_q[n]  <= bus_wdata[4'(n % 16)];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int n = 0; n < NUM_LINES; n++) begin
      if (bus_addr == reg_addr(MASK_OFF, n)) bus_rdata[4'(n % 16)] = mask_q[n];
      if (bus_addr == reg_addr(POL_OFF, n))  bus_rdata[4'(n % 16)] = pol_q[n];
    end
  end

  assign irq_out = ~mask_q & ((EDGE_LINES & latch_q) | (~EDGE_LINES & corr));

  generate
    if (NO_EOI == 0) begin : g_eoi_chk
      // R8
      latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((latch_q & ~eoi_clr) != '0) |=> (($past(latch_q & ~eoi_clr) & ~latch_q) == '0));
      // R9
      eoi_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((eoi_clr & ~rise) != '0) |=> (($past(eoi_clr & ~rise) & latch_q) == '0));
      // R10
      eoi_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((eoi_clr & rise) != '0) |=> (($past(eoi_clr & rise) & ~latch_q) == '0));
    end else begin : g_noeoi_chk
      // R11
      pulse_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q != '0) |=> ((latch_q & ~$past(rise)) == '0));
    end
  endgenerate

  // R6
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(sync1) |=> $stable(sync2));
endmodule

// File: tb/sim_irq_front.sv
module sim_irq_front;
  localparam int N = 20;
  localparam logic [63:0] EDGES = 64'h0000_0000_000F_F0F0;
  localparam logic [N-1:0] EM = EDGES[N-1:0];

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_in = '0;
  logic bus_wr = 0;
  logic [7:0] bus_addr = 8'h00;
  logic [15:0] bus_wdata = '0;
  logic [15:0] rd0, rd1;
  logic [N-1:0] out0, out1;
  int checks = 0, fails = 0;
  bit started = 0;

  always #5 clk = ~clk;

  irq_front #(.NUM_LINES(N), .EDGE_SEL(EDGES), .NO_EOI(0)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd0), .irq_out(out0));
  irq_front #(.NUM_LINES(N), .EDGE_SEL(EDGES), .NO_EOI(1)) u1 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd1), .irq_out(out1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] bank(input logic [7:0] a, input logic [15:0] d,
                                        input logic [7:0] base, input logic [N-1:0] cur);
    logic [N-1:0] r = cur;
    for (int n = 0; n < N; n++)
      if (a == base + 8'(4 * (n / 16))) r[n] = d[n % 16];
    return r;
  endfunction

  logic [N-1:0] h1, h2, prv, l0, l1, mm, pp;
  always @(posedge clk) begin
    logic [N-1:0] corr, rs, ev;
    if (!rst_n) begin
      h1 = '0; h2 = '0; prv = '0; l0 = '0; l1 = '0; mm = '1; pp = '0;
    end else begin
      corr = h2 ^ pp;
      rs = corr & ~prv;
      ev = bus_wr ? bank(bus_addr, bus_wdata, 8'h20, '0) : '0;
      l0 = rs | (l0 & ~ev);
      l1 = rs;
      prv = corr; h2 = h1; h1 = irq_in;
      if (bus_wr) begin
        mm = bank(bus_addr, bus_wdata, 8'h00, mm);
        pp = bank(bus_addr, bus_wdata, 8'h10, pp);
      end
    end
    #2;
    if (started) begin
      chk("R7 R8 R4 out handshake copy", 32'(out0), 32'(~mm & ((EM & l0) | (~EM & (h2 ^ pp)))));
      chk("R11 out no-handshake copy", 32'(out1), 32'(~mm & ((EM & l1) | (~EM & (h2 ^ pp)))));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [15:0] exp);
    @(negedge clk); bus_addr = a; #1;
    chk(tag, 32'(rd0), 32'(exp));
    chk(tag, 32'(rd1), 32'(exp));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] x = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1;
    started = 1;
    #1;
    // R1 reset state
    chk("R1 outputs after reset", 32'(out0 | out1), 0);
    rd("R1 mask group0 reset", 8'h00, 16'hFFFF);
    rd("R1 R2 mask group1 reset", 8'h04, 16'h000F);
    rd("R1 pol group0 reset", 8'h10, 16'h0000);
    // R3 / R2 readback
    wr(8'h00, 16'h0000);
    wr(8'h04, 16'hFFF0);
    rd("R3 mask group0 readback", 8'h00, 16'h0000);
    rd("R2 unused bits read 0", 8'h04, 16'h0000);
    rd("R2 unmapped address", 8'h08, 16'h0000);
    // R6 / R7 level line 0
    @(negedge clk); irq_in[0] = 1;
    @(posedge clk); #2; chk("R6 not after first edge", 32'(out0[0]), 0);
    @(posedge clk); #2; chk("R7 level after second edge", 32'(out0[0]), 1);
    @(negedge clk); irq_in[0] = 0;
    // R5 inversion on level line 1
    wr(8'h10, 16'h0002);
    #1; chk("R5 inverted idle line asserts", 32'(out0[1]), 1);
    rd("R3 pol readback", 8'h10, 16'h0002);
    wr(8'h10, 16'h0000);
    // R8 edge line 4
    @(negedge clk); irq_in[4] = 1;
    @(negedge clk); irq_in[4] = 0;
    repeat (4) @(negedge clk);
    #1; chk("R8 edge latched", 32'(out0[4]), 1);
    chk("R11 pulse gone", 32'(out1[4]), 0);
    wr(8'h20, 16'h0000);
    #1; chk("R9 zero EOI keeps latch", 32'(out0[4]), 1);
    rd("R9 EOI reads 0", 8'h20, 16'h0000);
    wr(8'h20, 16'h0010);
    #1; chk("R9 EOI clears", 32'(out0[4]), 0);
    // R10 race on line 5
    @(negedge clk); irq_in[5] = 1;
    @(negedge clk); irq_in[5] = 0;
    repeat (4) @(negedge clk);
    @(negedge clk); irq_in[5] = 1;
    @(negedge clk);
    wr(8'h20, 16'h0020);
    #1; chk("R10 edge with EOI kept", 32'(out0[5]), 1);
    wr(8'h20, 16'h0020);
    #1; chk("R9 release after race", 32'(out0[5]), 0);
    // R12 masked edge line 17 (group 1 bit 1)
    wr(8'h04, 16'h0002);
    @(negedge clk); irq_in[17] = 1;
    @(negedge clk); irq_in[17] = 0;
    repeat (4) @(negedge clk);
    #1; chk("R4 masked line silent", 32'(out0[17]), 0);
    wr(8'h04, 16'h0000);
    #1; chk("R12 pending shown on unmask", 32'(out0[17]), 1);
    // R5 falling edge on line 6 via inversion
    @(negedge clk); irq_in[6] = 1;
    wr(8'h10, 16'h0040);
    repeat (3) @(negedge clk);
    wr(8'h20, 16'h0040);
    #1; chk("R5 inverted high held quiet", 32'(out0[6]), 0);
    @(negedge clk); irq_in[6] = 0;
    repeat (4) @(negedge clk);
    #1; chk("R5 falling edge latched", 32'(out0[6]), 1);
    // mixed stimulus, compared every clock against the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      irq_in = x[N-1:0];
      bus_wr = (x[27:25] == 3'd0);
      case (x[30:28])
        3'd0: bus_addr = 8'h00;
        3'd1: bus_addr = 8'h04;
        3'd2: bus_addr = 8'h10;
        3'd3: bus_addr = 8'h14;
        default: bus_addr = x[28] ? 8'h24 : 8'h20;
      endcase
      bus_wdata = x[15:0] ^ x[31:16];
    end
    @(negedge clk); bus_wr = 0;
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule